// File: doc/BRIEF.md
# Missing-Clock Fast Activity Detector

This block watches the reference clock that the surrounding logic has selected. It samples that clock in a fast system clock domain. A programmable value gives the expected reference period, counted in system clock cycles. A counter measures the time since the last rising reference edge. When that time grows past two and a half periods, the block declares that the reference has gone quiet.

On that event it raises a hold output, which freezes the downstream loop at its current frequency. It also sets a sticky failure flag. From the flag it can drive an interrupt, a mirror pin, or both. If an option bit is set, it also issues a one-cycle request to switch to another reference. If reference edges come back before any slower qualification logic has rejected the input, hold drops on the first edge and locking simply continues. The sticky flag stays set until software clears it with a write-clear strobe.

Top module: `gap_watch`

## Requirements
- R1: After reset the outputs hold_o, switch_req_o, irq_o and mirror_o are all low.
- R2: While ref_i toggles steadily with a period of P system cycles (4 <= P), hold_o stays low.
- R3: Let T = 2P + floor(P/2). If no rising edge follows a rising edge of ref_i, hold_o rises between T+3 and T+5 system cycles after that edge.
- R4: Once hold_o is high, the first rising edge of ref_i clears it, and hold_o is low 4 cycles after that edge.
- R5: Each rise of hold_o sets a sticky flag. The flag stays set after hold_o clears and until stat_clr_i is high for one cycle. If a set and a clear arrive in the same cycle, the set wins.
- R6: irq_o equals the sticky flag when irq_mask_i is 0, and is 0 when irq_mask_i is 1.
- R7: When mirror_en_i is 1, mirror_o equals the sticky flag whatever irq_mask_i is. When mirror_en_i is 0, mirror_o is 0.
- R8: When fast_sw_en_i is 1, switch_req_o pulses high for exactly one cycle, in the same cycle that hold_o rises. When fast_sw_en_i is 0, it stays low.
- R9: A gap of at most T cycles after a rising edge produces no hold and leaves the sticky flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_i | input | 1 | Selected reference clock, asynchronous to clk_i |
| period_i | input | PER_W | Expected reference period in system cycles |
| fast_sw_en_i | input | 1 | Enables the immediate switch request |
| irq_mask_i | input | 1 | 1 masks the interrupt |
| mirror_en_i | input | 1 | Enables the sticky-flag mirror pin |
| stat_clr_i | input | 1 | Write-clear strobe for the sticky flag |
| hold_o | output | 1 | Freeze request to the downstream loop |
| switch_req_o | output | 1 | One-cycle immediate switch request |
| irq_o | output | 1 | Masked interrupt from the sticky flag |
| mirror_o | output | 1 | Unmasked copy of the sticky flag |

## Verification
The hardest situations to reach are at the edges of the threshold. One is a gap that ends just short of 2.5 periods, where no hold may appear. The other is a gap just past it, where hold must appear inside a narrow window. The stimulus reaches both by keeping a count of system cycles since the last rising edge it drove. It then extends each gap up to an exact target, chosen either at or below T or at least eight cycles beyond it. Randomized periods and control bits sweep the threshold arithmetic across odd and even periods. Before each round, the sticky flag is cleared with the reference running, so every gap is judged from a known flag state.

// File: rtl/gw_pkg.sv
package gw_pkg;
  typedef enum logic {
    GW_TRACK = 1'b0,
    GW_FROZEN = 1'b1
  } gw_mode_e;

  localparam int unsigned GW_SYNC_STAGES = 2;
endpackage

// File: rtl/gw_sync.sv
module gw_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n,
  input  logic ref_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], ref_i};
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/gw_gap_timer.sv
module gw_gap_timer #(
  parameter int unsigned PER_W = 16,
  localparam int unsigned CW = PER_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_n,
  input  logic             rise_i,
  input  logic [PER_W-1:0] period_i,
  output logic [CW-1:0]    cnt_o,
  output logic             over_o
);
  logic [CW-1:0] cnt_q, cnt_d, thr;
  logic          cnt_en;

  always_comb begin
    thr    = ({2'b00, period_i} << 1) + {3'b000, period_i[PER_W-1:1]};
    cnt_en = rise_i | (cnt_q != {CW{1'b1}});
    cnt_d  = rise_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign over_o = (cnt_q > thr) & ~rise_i;
endmodule

// File: rtl/gw_flags.sv
module gw_flags
  import gw_pkg::*;
(
  input  logic clk_i,
  input  logic rst_n,
  input  logic rise_i,
  input  logic over_i,
  input  logic fast_sw_en_i,
  input  logic irq_mask_i,
  input  logic mirror_en_i,
  input  logic stat_clr_i,
  output logic hold_o,
  output logic switch_req_o,
  output logic irq_o,
  output logic mirror_o,
  output logic stat_o
);
  gw_mode_e mode_q, mode_d;
  logic     stat_q, stat_d;
  logic     sw_q, sw_d;
  logic     fail_set;

  always_comb begin
    fail_set = over_i & (mode_q == GW_TRACK);
    mode_d   = mode_q;
    if (rise_i)      mode_d = GW_TRACK;
    else if (over_i) mode_d = GW_FROZEN;
    stat_d = stat_q;
    if (fail_set)        stat_d = 1'b1;
    else if (stat_clr_i) stat_d = 1'b0;
    sw_d = fail_set & fast_sw_en_i;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= GW_TRACK;
      stat_q <= 1'b0;
      sw_q   <= 1'b0;
    end else begin
      mode_q <= mode_d;
      stat_q <= stat_d;
      sw_q   <= sw_d;
    end
  end

  assign hold_o       = (mode_q == GW_FROZEN);
  assign switch_req_o = sw_q;
  assign irq_o        = stat_q & ~irq_mask_i;
  assign mirror_o     = stat_q & mirror_en_i;
  assign stat_o       = stat_q;
endmodule

// File: rtl/gap_watch.sv
module gap_watch #(
  parameter int unsigned PER_W = 16,
  localparam int unsigned CW = PER_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_i,
  input  logic [PER_W-1:0] period_i,
  input  logic             fast_sw_en_i,
  input  logic             irq_mask_i,
  input  logic             mirror_en_i,
  input  logic             stat_clr_i,
  output logic             hold_o,
  output logic             switch_req_o,
  output logic             irq_o,
  output logic             mirror_o
);
  logic [1:0]    rst_sync_q;
  logic          rst_n;
  logic          ref_rise;
  logic          gap_over;
  logic [CW-1:0] gap_cnt;
  logic          stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  gw_sync #(.STAGES(gw_pkg::GW_SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_n  (rst_n),
    .ref_i  (ref_i),
    .rise_o (ref_rise)
  );

  gw_gap_timer #(.PER_W(PER_W)) u_timer (
    .clk_i    (clk_i),
    .rst_n    (rst_n),
    .rise_i   (ref_rise),
    .period_i (period_i),
    .cnt_o    (gap_cnt),
    .over_o   (gap_over)
  );

  gw_flags u_flags (
    .clk_i        (clk_i),
    .rst_n        (rst_n),
    .rise_i       (ref_rise),
    .over_i       (gap_over),
    .fast_sw_en_i (fast_sw_en_i),
    .irq_mask_i   (irq_mask_i),
    .mirror_en_i  (mirror_en_i),
    .stat_clr_i   (stat_clr_i),
    .hold_o       (hold_o),
    .switch_req_o (switch_req_o),
    .irq_o        (irq_o),
    .mirror_o     (mirror_o),
    .stat_o       (stat_q)
  );
endmodule

// File: rtl/gap_watch_chk.sv
module gap_watch_chk #(
  parameter int unsigned PER_W = 16,
  localparam int unsigned CW = PER_W + 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [PER_W-1:0] period_i,
  input logic             fast_sw_en_i,
  input logic             irq_mask_i,
  input logic             mirror_en_i,
  input logic             stat_clr_i,
  input logic             ref_rise,
  input logic [CW-1:0]    gap_cnt,
  input logic             stat_q,
  input logic             hold_o,
  input logic             switch_req_o,
  input logic             irq_o,
  input logic             mirror_o
);
  // R3
  hold_late_enough_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_o) |-> ($past(gap_cnt) >= ({2'b00, $past(period_i)} << 1)));

  // R4
  hold_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_o) |-> $past(ref_rise));

  // R4
  hold_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o && !ref_rise) |=> hold_o);

  // R5
  sticky_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q && !stat_clr_i) |=> stat_q);

  // R6
  irq_on_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(hold_o) && !irq_mask_i) |-> irq_o);

  // R7
  mirror_on_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(hold_o) && mirror_en_i) |-> mirror_o);

  // R8
  switch_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switch_req_o |=> !switch_req_o);

  // R8
  switch_with_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switch_req_o |-> ($rose(hold_o) && $past(fast_sw_en_i)));
endmodule

bind gap_watch gap_watch_chk #(.PER_W(PER_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .period_i     (period_i),
  .fast_sw_en_i (fast_sw_en_i),
  .irq_mask_i   (irq_mask_i),
  .mirror_en_i  (mirror_en_i),
  .stat_clr_i   (stat_clr_i),
  .ref_rise     (ref_rise),
  .gap_cnt      (gap_cnt),
  .stat_q       (stat_q),
  .hold_o       (hold_o),
  .switch_req_o (switch_req_o),
  .irq_o        (irq_o),
  .mirror_o     (mirror_o)
);

// File: tb/gap_watch_tb.sv
module gap_watch_tb;
  localparam int unsigned PER_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ref_s = 1'b0;
  logic [PER_W-1:0] period = 16'd10;
  logic             fast_en = 1'b0;
  logic             mask = 1'b0;
  logic             mir_en = 1'b0;
  logic             clr = 1'b0;
  logic             hold, swr, irq, mir;

  int checks = 0;
  int errors = 0;
  int since_rise = 0;
  int rose_at = -1;
  int sw_cnt = 0;
  int hold_cyc = 0;
  logic hold_prev = 1'b0;

  always #2 clk = ~clk;

  gap_watch #(.PER_W(PER_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_i(ref_s), .period_i(period),
    .fast_sw_en_i(fast_en), .irq_mask_i(mask), .mirror_en_i(mir_en),
    .stat_clr_i(clr), .hold_o(hold), .switch_req_o(swr), .irq_o(irq),
    .mirror_o(mir)
  );

  function automatic int thr_of(input int p);
    return 2 * p + p / 2;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic clear_mon();
    rose_at = -1; sw_cnt = 0; hold_cyc = 0;
  endtask

  task automatic step(input logic r, input logic c);
    @(negedge clk);
    if (hold && !hold_prev && rose_at < 0) rose_at = since_rise;
    hold_prev = hold;
    if (swr) sw_cnt++;
    if (hold) hold_cyc++;
    if (r && !ref_s) since_rise = 0;
    else since_rise++;
    ref_s = r;
    clr = c;
  endtask

  task automatic run_ref(input int p, input int n);
    for (int i = 0; i < n; i++) begin
      repeat (p / 2) step(1'b1, 1'b0);
      repeat (p - p / 2) step(1'b0, 1'b0);
    end
  endtask

  task automatic gap_to(input int target);
    while (since_rise < target) step(1'b0, 1'b0);
  endtask

  task automatic pulse_clr();
    step(ref_s, 1'b1);
    step(ref_s, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int p, t, n;
    logic lg;
    logic exp_st;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 hold", int'(hold), 0);
    chk("R1 switch", int'(swr), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 mirror", int'(mir), 0);

    // directed: P=10, fast switch and mirror on
    period = 16'd10; fast_en = 1'b1; mir_en = 1'b1; mask = 1'b0;
    run_ref(10, 4);
    pulse_clr();
    clear_mon();
    run_ref(10, 6);
    chk("R2 steady no hold", hold_cyc, 0);
    gap_to(thr_of(10) + 10);
    chk_rng("R3 latency", rose_at, thr_of(10) + 3, thr_of(10) + 5);
    chk("R8 one pulse", sw_cnt, 1);
    chk("R6 irq set", int'(irq), 1);
    chk("R7 mirror set", int'(mir), 1);
    run_ref(10, 1);
    chk("R4 hold cleared", int'(hold), 0);
    run_ref(10, 3);
    chk("R5 sticky kept", int'(irq), 1);
    pulse_clr();
    chk("R5 cleared irq", int'(irq), 0);
    chk("R5 cleared mirror", int'(mir), 0);

    // R9 gap exactly at threshold
    clear_mon();
    run_ref(9, 2);
    period = 16'd9;
    run_ref(9, 2);
    pulse_clr();
    clear_mon();
    step(1'b1, 1'b0);
    gap_to(thr_of(9));
    run_ref(9, 2);
    chk("R9 no hold at T", hold_cyc, 0);
    chk("R9 sticky untouched", int'(irq), 0);

    // masked, fast switch off
    mask = 1'b1; fast_en = 1'b0; mir_en = 1'b1;
    clear_mon();
    step(1'b1, 1'b0);
    gap_to(thr_of(9) + 12);
    chk("R6 masked irq", int'(irq), 0);
    chk("R7 mirror ignores mask", int'(mir), 1);
    chk("R8 no pulse when off", sw_cnt, 0);
    mir_en = 1'b0;
    step(1'b0, 1'b0);
    chk("R7 mirror disabled", int'(mir), 0);
    run_ref(9, 2);
    pulse_clr();

    // random rounds
    for (int k = 0; k < 40; k++) begin
      p = 4 + int'($urandom_range(36));
      t = thr_of(p);
      period = PER_W'(p);
      fast_en = 1'($urandom_range(1));
      mask = 1'($urandom_range(1));
      mir_en = 1'($urandom_range(1));
      lg = 1'($urandom_range(1));
      n = 2 + int'($urandom_range(3));
      run_ref(p, 3);
      pulse_clr();
      run_ref(p, 1);
      clear_mon();
      run_ref(p, n);
      chk("R2 random steady", hold_cyc, 0);
      step(1'b1, 1'b0);
      if (lg) gap_to(t + 8 + int'($urandom_range(20)));
      else gap_to(t - int'($urandom_range(p)));
      exp_st = lg;
      if (lg) chk_rng("R3 random latency", rose_at, t + 3, t + 5);
      else chk("R9 random short gap", hold_cyc, 0);
      chk("R8 random pulses", sw_cnt, (lg && fast_en) ? 1 : 0);
      chk("R6 random irq", int'(irq), int'(exp_st & ~mask));
      chk("R7 random mirror", int'(mir), int'(exp_st & mir_en));
      step(1'b1, 1'b0);
      repeat (4) step(1'b1, 1'b0);
      chk("R4 random release", int'(hold), 0);
      chk("R5 random sticky", int'(mir | irq), int'(exp_st & (mir_en | ~mask)));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule